// File: doc/BRIEF.md
# Global-History Direction Predictor with Return-Address Stack

This block predicts the direction of conditional branches and the targets of subroutine returns for an in-order core. For each fetched branch it combines a 12-bit global outcome history with PC bits [13:2] by XOR to address 4096 two-bit saturating counters. A call pushes its fall-through address (PC+4) onto an 8-entry circular return stack, and a return pops that stack to supply its target. The prediction appears one clock after the fetch request. It carries the table index and counter value that were used, so the core can hand them back when the branch resolves.

The block keeps two copies of both the history and the stack. The speculative pair advances at prediction time. The committed pair advances when the resolve port reports each branch's actual behaviour. When a resolve is flagged as mispredicted, the speculative pair is overwritten in that same cycle with the committed pair, including the effect of the resolving branch. Fetch order and target lookup for non-return branches lie outside this block.

Top module: `branch_dir_ras`

## Requirements
- R1: After power-up every direction counter holds 1 (weakly not-taken), so the first prediction at any index reports counter 1 and not-taken.
- R2: `pred_idx` equals the speculative history XOR `fetch_pc[13:2]`. The speculative history includes the outcome predicted for a conditional fetched in the cycle just before.
- R3: Results appear in the cycle after the fetch. Kind codes are 0 none, 1 conditional, 2 call, 3 return. A conditional is predicted taken exactly when its counter is 2 or 3. Calls and returns are always predicted taken, and a non-branch is predicted not-taken.
- R4: A resolved conditional writes to `res_idx` the value `res_ctr`, stepped up when taken or down when not taken, and saturated at 3 and 0.
- R5: Each predicted conditional shifts its predicted direction into the low bit of the speculative history. A conditional fetched in the very next cycle already sees that bit.
- R6: Each resolved conditional shifts its actual outcome into the low bit of the committed history.
- R7: A fetched call pushes PC+4 onto the speculative stack. A fetched return reports the top entry on `pred_target` and pops it. `pred_target` is zero for all other kinds.
- R8: The stack holds 8 entries. A ninth push overwrites the oldest entry, so eight pops then return the eight newest addresses.
- R9: A pop from an empty stack returns the most recently written entry and leaves the stack unchanged.
- R10: A resolve with `res_mispredict` set copies the committed history and stack, after this resolve's own update, into the speculative copies in the same cycle. A fetch presented in that cycle is dropped, so `pred_valid` is low in the next cycle.
- R11: Synchronous reset clears both histories, empties both stacks (entries zero) and drives `pred_valid` low. The counter table keeps its contents across reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| fetch_valid | input | 1 | A branch is fetched this cycle |
| fetch_pc | input | 32 | Address of the fetched branch |
| fetch_kind | input | 2 | 0 none, 1 conditional, 2 call, 3 return |
| res_valid | input | 1 | A branch resolves this cycle |
| res_kind | input | 2 | Kind of the resolving branch, same coding |
| res_pc | input | 32 | Address of the resolving branch |
| res_taken | input | 1 | Actual direction of the resolving branch |
| res_mispredict | input | 1 | Resolving branch was mispredicted; recover |
| res_idx | input | 12 | Table index reported at prediction time |
| res_ctr | input | 2 | Counter value reported at prediction time |
| pred_valid | output | 1 | Prediction for last cycle's fetch is present |
| pred_taken | output | 1 | Predicted direction |
| pred_target | output | 32 | Predicted return target, zero otherwise |
| pred_idx | output | 12 | Table index used for this prediction |
| pred_ctr | output | 2 | Counter value read for a conditional, zero otherwise |

## Verification
On every cycle, the assertions check that the speculative history takes in the predicted bit and the committed history the resolved bit. They also check that recovery makes the speculative copies equal the committed ones and drops the concurrent fetch, that a pushed address becomes the stack top, that stack occupancy never passes the depth, and that an empty pop changes nothing. Some behaviours only the bench scenarios can show: counters learning loop, alternating and always/never patterns under the hashed index, counter saturation at both ends, return targets in LIFO order across overflow, and the index a fetch sees right after a mispredict. The bench also confirms that counters survive a mid-run reset while the histories and stacks do not.

// File: rtl/bp_pkg.sv
package bp_pkg;

  typedef enum logic [1:0] {
    BK_NONE = 2'd0,
    BK_COND = 2'd1,
    BK_CALL = 2'd2,
    BK_RET  = 2'd3
  } br_kind_e;

  // Saturating two-bit counter step
  function automatic logic [1:0] ctr_step(input logic [1:0] c, input logic up);
    if (up) return (c == 2'd3) ? 2'd3 : c + 2'd1;
    else    return (c == 2'd0) ? 2'd0 : c - 2'd1;
  endfunction

endpackage

// File: rtl/bp_dir_table.sv
module bp_dir_table #(
  parameter int          IDX_W    = 12,
  parameter logic [1:0]  INIT_CTR = 2'b01
) (
  input  logic             clk,
  input  logic             rd_en,
  input  logic [IDX_W-1:0] rd_idx,
  output logic [1:0]       rd_ctr,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic [1:0]       wr_ctr
);
  localparam int ENTRIES = 1 << IDX_W;

  logic [1:0] mem [ENTRIES];

  // Power-up contents (R1): weakly not-taken everywhere
  initial begin
    for (int i = 0; i < ENTRIES; i++) mem[i] <= INIT_CTR;
  end

  // Simple dual-port: one write port, one registered read port (read-old)
  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_idx] <= wr_ctr;
  end

  always_ff @(posedge clk) begin
    if (rd_en) rd_ctr <= mem[rd_idx];
  end

endmodule

// File: rtl/bp_return_stack.sv
module bp_return_stack #(
  parameter int DEPTH = 8,
  parameter int AW    = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          spec_push,
  input  logic          spec_pop,
  input  logic [AW-1:0] spec_addr,
  input  logic          arch_push,
  input  logic          arch_pop,
  input  logic [AW-1:0] arch_addr,
  input  logic          restore,
  output logic [AW-1:0] top_addr
);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  typedef struct packed {
    logic [DEPTH-1:0][AW-1:0] ent;
    logic [PW-1:0]            ptr;  // slot holding the current top
    logic [CW-1:0]            cnt;  // live entries
    logic [PW-1:0]            lw;   // slot written most recently
  } ras_t;

  function automatic ras_t step(input ras_t s, input logic push, input logic pop,
                                input logic [AW-1:0] a);
    ras_t          n;
    logic [PW-1:0] wp;
    n  = s;
    wp = (s.ptr == PW'(DEPTH - 1)) ? '0 : s.ptr + 1'b1;
    if (push) begin
      n.ent[wp] = a;
      n.ptr     = wp;
      n.lw      = wp;
      if (s.cnt != CW'(DEPTH)) n.cnt = s.cnt + 1'b1;
    end else if (pop && s.cnt != '0) begin
      n.ptr = (s.ptr == '0) ? PW'(DEPTH - 1) : s.ptr - 1'b1;
      n.cnt = s.cnt - 1'b1;
    end
    return n;
  endfunction

  ras_t spec_q, arch_q, spec_nx, arch_nx;

  always_comb begin
    arch_nx = step(arch_q, arch_push, arch_pop, arch_addr);
    spec_nx = restore ? arch_nx : step(spec_q, spec_push, spec_pop, spec_addr);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      spec_q <= '0;
      arch_q <= '0;
    end else begin
      spec_q <= spec_nx;
      arch_q <= arch_nx;
    end
  end

  assign top_addr = (spec_q.cnt == '0) ? spec_q.ent[spec_q.lw] : spec_q.ent[spec_q.ptr];

  a_r8_occupancy_bound: assert property (@(posedge clk) disable iff (rst)
    (spec_q.cnt <= CW'(DEPTH)) && (arch_q.cnt <= CW'(DEPTH)));

  a_r7_push_lands_on_top: assert property (@(posedge clk) disable iff (rst)
    spec_push && !restore |=> top_addr == $past(spec_addr));

  a_r9_empty_pop_keeps: assert property (@(posedge clk) disable iff (rst)
    spec_pop && !spec_push && !restore && spec_q.cnt == '0
    |=> spec_q.cnt == '0 && top_addr == $past(top_addr));

  a_r10_stack_restored: assert property (@(posedge clk) disable iff (rst)
    restore |=> spec_q == arch_q);

endmodule

// File: rtl/branch_dir_ras.sv
module branch_dir_ras #(
  parameter int PC_W      = 32,
  parameter int IDX_W     = 12,
  parameter int RAS_DEPTH = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             fetch_valid,
  input  logic [PC_W-1:0]  fetch_pc,
  input  logic [1:0]       fetch_kind,
  input  logic             res_valid,
  input  logic [1:0]       res_kind,
  input  logic [PC_W-1:0]  res_pc,
  input  logic             res_taken,
  input  logic             res_mispredict,
  input  logic [IDX_W-1:0] res_idx,
  input  logic [1:0]       res_ctr,
  output logic             pred_valid,
  output logic             pred_taken,
  output logic [PC_W-1:0]  pred_target,
  output logic [IDX_W-1:0] pred_idx,
  output logic [1:0]       pred_ctr
);
  import bp_pkg::*;

  localparam int          HIST_W = IDX_W;
  localparam logic [PC_W-1:0] INSN_BYTES = PC_W'(4);

  br_kind_e f_kind, r_kind, kind_q;
  logic     flush, accept, pend_cond, res_cond;
  logic [HIST_W-1:0] spec_hist_q, arch_hist_q, spec_hist_now, arch_hist_nx;
  logic [IDX_W-1:0]  fetch_idx, idx_q;
  logic [PC_W-1:0]   ras_top, tgt_q;
  logic              pv_q;
  logic [1:0]        rd_ctr;

  assign f_kind    = br_kind_e'(fetch_kind);
  assign r_kind    = br_kind_e'(res_kind);
  assign flush     = res_valid && res_mispredict;
  assign accept    = fetch_valid && !flush;
  assign res_cond  = res_valid && (r_kind == BK_COND);
  assign pend_cond = pv_q && (kind_q == BK_COND);

  // Bypass the prediction made last cycle into the history used now
  assign spec_hist_now = pend_cond ? {spec_hist_q[HIST_W-2:0], rd_ctr[1]} : spec_hist_q;
  assign arch_hist_nx  = res_cond  ? {arch_hist_q[HIST_W-2:0], res_taken} : arch_hist_q;
  assign fetch_idx     = spec_hist_now ^ fetch_pc[IDX_W+1:2];

  bp_dir_table #(.IDX_W(IDX_W), .INIT_CTR(2'b01)) u_table (
    .clk    (clk),
    .rd_en  (accept && f_kind == BK_COND),
    .rd_idx (fetch_idx),
    .rd_ctr (rd_ctr),
    .wr_en  (res_cond),
    .wr_idx (res_idx),
    .wr_ctr (ctr_step(res_ctr, res_taken))
  );

  bp_return_stack #(.DEPTH(RAS_DEPTH), .AW(PC_W)) u_ras (
    .clk       (clk),
    .rst       (rst),
    .spec_push (accept && f_kind == BK_CALL),
    .spec_pop  (accept && f_kind == BK_RET),
    .spec_addr (fetch_pc + INSN_BYTES),
    .arch_push (res_valid && r_kind == BK_CALL),
    .arch_pop  (res_valid && r_kind == BK_RET),
    .arch_addr (res_pc + INSN_BYTES),
    .restore   (flush),
    .top_addr  (ras_top)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      spec_hist_q <= '0;
      arch_hist_q <= '0;
      pv_q        <= 1'b0;
      kind_q      <= BK_NONE;
      idx_q       <= '0;
      tgt_q       <= '0;
    end else begin
      arch_hist_q <= arch_hist_nx;
      spec_hist_q <= flush ? arch_hist_nx : spec_hist_now;
      pv_q        <= accept;
      kind_q      <= f_kind;
      idx_q       <= fetch_idx;
      tgt_q       <= (accept && f_kind == BK_RET) ? ras_top : '0;
    end
  end

  always_comb begin
    pred_taken = 1'b0;
    if (pv_q) begin
      case (kind_q)
        BK_COND:         pred_taken = rd_ctr[1];
        BK_CALL, BK_RET: pred_taken = 1'b1;
        default:         pred_taken = 1'b0;
      endcase
    end
  end

  assign pred_valid  = pv_q;
  assign pred_target = tgt_q;
  assign pred_idx    = idx_q;
  assign pred_ctr    = pend_cond ? rd_ctr : 2'b00;

  a_r5_spec_shift: assert property (@(posedge clk) disable iff (rst)
    pend_cond && !flush
    |=> spec_hist_q == {$past(spec_hist_q[HIST_W-2:0]), $past(rd_ctr[1])});

  a_r6_commit_shift: assert property (@(posedge clk) disable iff (rst)
    res_cond |=> arch_hist_q[0] == $past(res_taken));

  a_r10_hist_restored: assert property (@(posedge clk) disable iff (rst)
    flush |=> spec_hist_q == arch_hist_q);

  a_r10_fetch_dropped: assert property (@(posedge clk) disable iff (rst)
    flush |=> !pred_valid);

endmodule

// File: tb/test_branch_dir_ras.sv
`timescale 1ns/1ps
module test_branch_dir_ras;
  localparam logic [1:0] K_NONE = 2'd0, K_COND = 2'd1, K_CALL = 2'd2, K_RET = 2'd3;

  typedef struct packed {
    logic [31:0] pc;
    logic [1:0]  kind;
    logic [15:0] pat;
    int          cnt;
  } vec_t;

  // Stimulus rows: branch address, kind, outcome pattern (bit i%16), repeat count
  localparam vec_t VECS [6] = '{
    '{32'h0000_1000, K_COND, 16'h7F7F, 48},  // loop: 7 taken, 1 exit
    '{32'h0000_2004, K_COND, 16'h5555, 32},  // alternating
    '{32'h0000_3000, K_CALL, 16'h0000, 4},
    '{32'h0000_3000, K_RET,  16'h0000, 4},
    '{32'h0000_4FF8, K_COND, 16'h0000, 8},   // never taken
    '{32'h0000_5000, K_COND, 16'hFFFF, 8}    // always taken
  };

  logic        clk = 1'b0, rst = 1'b1;
  logic        fetch_valid = 1'b0, res_valid = 1'b0, res_taken = 1'b0, res_mispredict = 1'b0;
  logic [31:0] fetch_pc = '0, res_pc = '0;
  logic [1:0]  fetch_kind = '0, res_kind = '0, res_ctr = '0;
  logic [11:0] res_idx = '0;
  logic        pred_valid, pred_taken;
  logic [31:0] pred_target;
  logic [11:0] pred_idx;
  logic [1:0]  pred_ctr;

  always #2.5 clk = ~clk;

  branch_dir_ras i_branch_dir_ras (
    .clk(clk), .rst(rst),
    .fetch_valid(fetch_valid), .fetch_pc(fetch_pc), .fetch_kind(fetch_kind),
    .res_valid(res_valid), .res_kind(res_kind), .res_pc(res_pc), .res_taken(res_taken),
    .res_mispredict(res_mispredict), .res_idx(res_idx), .res_ctr(res_ctr),
    .pred_valid(pred_valid), .pred_taken(pred_taken), .pred_target(pred_target),
    .pred_idx(pred_idx), .pred_ctr(pred_ctr)
  );

  int checks = 0, failures = 0;
  bit done = 1'b0;

  // Reference model state
  logic [1:0]  mtab [4096];
  logic [11:0] m_spec_h, m_arch_h;
  logic [31:0] sq[$], aq[$];
  logic [31:0] s_last, a_last;

  function automatic logic [1:0] sat(input logic [1:0] c, input bit t);
    case ({t, c})
      3'b1_00: return 2'd1;
      3'b1_01: return 2'd2;
      3'b1_10: return 2'd3;
      3'b1_11: return 2'd3;
      3'b0_00: return 2'd0;
      3'b0_01: return 2'd0;
      3'b0_10: return 2'd1;
      default: return 2'd2;
    endcase
  endfunction

  task automatic m_push(input bit arch, input logic [31:0] a);
    if (arch) begin
      if (aq.size() == 8) void'(aq.pop_front());
      aq.push_back(a); a_last = a;
    end else begin
      if (sq.size() == 8) void'(sq.pop_front());
      sq.push_back(a); s_last = a;
    end
  endtask

  function automatic logic [31:0] m_pop(input bit arch);
    if (arch) return (aq.size() == 0) ? a_last : aq.pop_back();
    else      return (sq.size() == 0) ? s_last : sq.pop_back();
  endfunction

  task automatic check(input string tag, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  // One clock: drive at negedge, model it, check outputs at the next negedge
  task automatic cycle(input string tag, input bit fv, input logic [31:0] pc,
                       input logic [1:0] kind, input bit rv, input logic [1:0] rkind,
                       input logic [31:0] rpc, input bit rtaken, input bit rmis,
                       input logic [11:0] ridx, input logic [1:0] rctr,
                       output logic [11:0] e_idx, output logic [1:0] e_ctr,
                       output bit e_taken, output logic [31:0] e_tgt);
    bit e_valid;
    fetch_valid = fv; fetch_pc = pc; fetch_kind = kind;
    res_valid = rv; res_kind = rkind; res_pc = rpc; res_taken = rtaken;
    res_mispredict = rmis; res_idx = ridx; res_ctr = rctr;
    e_valid = fv && !(rv && rmis);
    e_idx   = m_spec_h ^ pc[13:2];
    e_ctr   = (kind == K_COND) ? mtab[e_idx] : 2'd0;
    e_taken = (kind == K_COND) ? e_ctr[1] : (kind == K_CALL || kind == K_RET);
    e_tgt   = '0;
    if (e_valid) begin
      if (kind == K_COND)      m_spec_h = {m_spec_h[10:0], e_taken};
      else if (kind == K_CALL) m_push(1'b0, pc + 32'd4);
      else if (kind == K_RET)  e_tgt = m_pop(1'b0);
    end
    if (rv) begin
      if (rkind == K_COND) begin
        mtab[ridx] = sat(rctr, rtaken);
        m_arch_h   = {m_arch_h[10:0], rtaken};
      end else if (rkind == K_CALL) m_push(1'b1, rpc + 32'd4);
      else if (rkind == K_RET) void'(m_pop(1'b1));
      if (rmis) begin
        m_spec_h = m_arch_h; sq = aq; s_last = a_last;
      end
    end
    @(negedge clk);
    fetch_valid = 1'b0; res_valid = 1'b0; res_mispredict = 1'b0;
    check(tag, "pred_valid", 64'(pred_valid), 64'(e_valid));
    if (e_valid)
      check(tag, "idx/ctr/taken/target",
            64'({pred_idx, pred_ctr, pred_taken, pred_target}),
            64'({e_idx, e_ctr, e_taken, e_tgt}));
  endtask

  task automatic fetch(input string tag, input logic [31:0] pc, input logic [1:0] kind,
                       output logic [11:0] ix, output logic [1:0] cx, output bit tk,
                       output logic [31:0] tg);
    cycle(tag, 1'b1, pc, kind, 1'b0, K_NONE, '0, 1'b0, 1'b0, '0, '0, ix, cx, tk, tg);
  endtask

  task automatic resolve(input string tag, input logic [1:0] kind, input logic [31:0] pc,
                         input bit taken, input bit mis, input logic [11:0] ix,
                         input logic [1:0] cx);
    logic [11:0] d_i; logic [1:0] d_c; bit d_t; logic [31:0] d_g;
    cycle(tag, 1'b0, '0, K_NONE, 1'b1, kind, pc, taken, mis, ix, cx, d_i, d_c, d_t, d_g);
  endtask

  task automatic summary;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; failures++;
      $display("FAIL watchdog run did not finish actual=hung expected=done");
      summary();
      $finish;
    end
  end

  initial begin
    logic [11:0] ix, h0, idx_a;
    logic [1:0]  cx, ctr_a;
    bit          tk, act;
    logic [31:0] tg, pc;

    for (int i = 0; i < 4096; i++) mtab[i] = 2'd1;
    m_spec_h = '0; m_arch_h = '0; s_last = '0; a_last = '0;

    repeat (3) @(negedge clk);
    check("R11", "pred_valid in reset", 64'(pred_valid), 64'(0));
    rst = 1'b0;
    @(negedge clk);
    check("R11", "pred_valid idle", 64'(pred_valid), 64'(0));

    // First conditional after power-up
    fetch("R1", 32'h40, K_COND, ix, cx, tk, tg);
    check("R2", "index with zero history", 64'(pred_idx), 64'(12'h010));
    check("R1", "initial counter", 64'(pred_ctr), 64'(1));
    check("R3", "weak not-taken", 64'(pred_taken), 64'(0));
    resolve("R6", K_COND, 32'h40, 1'b0, 1'b0, ix, cx);

    // Table walk: loop, alternating, call/return, never and always patterns
    for (int v = 0; v < 6; v++) begin
      for (int i = 0; i < VECS[v].cnt; i++) begin
        pc  = (VECS[v].kind == K_COND) ? VECS[v].pc : VECS[v].pc + 32'(i * 16);
        act = VECS[v].pat[i % 16];
        if (VECS[v].kind == K_COND) begin
          fetch("R3", pc, K_COND, ix, cx, tk, tg);
          resolve("R4", K_COND, pc, act, act != tk, ix, cx);
        end else begin
          fetch("R7", pc, VECS[v].kind, ix, cx, tk, tg);
          resolve("R7", VECS[v].kind, pc, 1'b1, 1'b0, ix, cx);
        end
      end
    end

    // R4 saturation at both ends
    resolve("R4", K_COND, '0, 1'b1, 1'b0, 12'h123, 2'd3);
    pc = {18'h0, 12'h123 ^ m_spec_h, 2'b00};
    fetch("R4", pc, K_COND, ix, cx, tk, tg);
    check("R4", "saturate high", 64'(pred_ctr), 64'(3));
    resolve("R4", K_COND, '0, 1'b0, 1'b0, 12'h123, 2'd0);
    pc = {18'h0, 12'h123 ^ m_spec_h, 2'b00};
    fetch("R4", pc, K_COND, ix, cx, tk, tg);
    check("R4", "saturate low", 64'(pred_ctr), 64'(0));
    resolve("R4", K_COND, '0, 1'b0, 1'b0, 12'h123, 2'd2);
    pc = {18'h0, 12'h123 ^ m_spec_h, 2'b00};
    fetch("R3", pc, K_COND, ix, cx, tk, tg);
    check("R3", "counter 1 is not-taken", 64'({pred_ctr, pred_taken}), 64'({2'd1, 1'b0}));

    // R5 back-to-back conditionals see the first prediction
    resolve("R5", K_COND, '0, 1'b1, 1'b0, 12'h2AA, 2'd3);
    h0 = m_spec_h;
    pc = {18'h0, 12'h2AA ^ h0, 2'b00};
    fetch("R5", pc, K_COND, idx_a, ctr_a, tk, tg);
    check("R5", "first predicted taken", 64'(pred_taken), 64'(1));
    fetch("R5", 32'h0000_0ABC, K_COND, ix, cx, tk, tg);
    check("R5", "back-to-back index", 64'(pred_idx), 64'({h0[10:0], 1'b1} ^ 12'h2AF));

    // R10 mispredict recovery with a concurrent fetch
    fetch("R7", 32'h0000_6000, K_CALL, ix, cx, tk, tg);
    cycle("R10", 1'b1, 32'h7000, K_COND, 1'b1, K_COND, pc, 1'b0, 1'b1, idx_a, ctr_a,
          ix, cx, tk, tg);
    fetch("R10", 32'h0000_7100, K_RET, ix, cx, tk, tg);
    check("R10", "speculative call discarded", 64'(pred_target == 32'h6004), 64'(0));
    h0 = m_arch_h;
    fetch("R6", 32'h0, K_COND, ix, cx, tk, tg);
    check("R6", "index from committed history", 64'(pred_idx), 64'(h0));

    // R8 overflow and R9 empty pops
    for (int i = 0; i < 9; i++) fetch("R8", 32'h8000 + 32'(i * 16), K_CALL, ix, cx, tk, tg);
    for (int i = 0; i < 8; i++) begin
      fetch("R8", 32'h8800, K_RET, ix, cx, tk, tg);
      if (i == 0) check("R7", "newest return first", 64'(pred_target), 64'(32'h8084));
      if (i == 7) check("R8", "oldest overwritten", 64'(pred_target), 64'(32'h8014));
    end
    fetch("R9", 32'h8800, K_RET, ix, cx, tk, tg);
    check("R9", "empty pop gives last written", 64'(pred_target), 64'(32'h8084));
    fetch("R9", 32'h8800, K_RET, ix, cx, tk, tg);
    check("R9", "empty pop leaves stack", 64'(pred_target), 64'(32'h8084));
    fetch("R9", 32'h9000, K_CALL, ix, cx, tk, tg);
    fetch("R9", 32'h8800, K_RET, ix, cx, tk, tg);
    check("R9", "push after empty", 64'(pred_target), 64'(32'h9004));

    // R11 mid-run reset: histories and stacks clear, table kept
    rst = 1'b1;
    @(negedge clk);
    check("R11", "pred_valid after reset", 64'(pred_valid), 64'(0));
    rst = 1'b0;
    m_spec_h = '0; m_arch_h = '0; sq.delete(); aq.delete(); s_last = '0; a_last = '0;
    fetch("R11", 32'h0000_0100, K_RET, ix, cx, tk, tg);
    check("R11", "empty stack target", 64'(pred_target), 64'(0));
    fetch("R11", 32'h0000_1ABC, K_COND, ix, cx, tk, tg);
    check("R11", "history cleared", 64'(pred_idx), 64'(12'h6AF));

    done = 1'b1;
    summary();
    $finish;
  end

endmodule